// File: doc/BRIEF.md
# Timed Video Format Switch Sequencer

This block drives the format-select code of an internal test-pattern generator while a receiver is being tested for reliability. The control side sets a 2-bit mode and two 4-bit format codes, A and B. Each switching interval the sequencer moves its format output to the next code of the pattern that the mode picks. Whenever the code it presents changes, it raises a one-cycle new-source pulse, so that a downstream lock checker can start measuring again.

The interval is given in clock cycles as the product of the clock rate in hertz and the interval length in seconds. By default this is 3 seconds at 100 MHz. A simulation can shrink both values. When the mode or either code changes, the pattern restarts at once from its start code and the interval timer starts over.

Top module: `fsw_sequencer`

## Requirements
- R1: While rst_ni is low, fmt_o is 0 and new_src_o is 0.
- R2: On the first clock edge after reset is released, fmt_o takes the start code of the current mode and new_src_o stays 0. The start code is code_b_i for mode 3 and code_a_i for modes 0, 1 and 2.
- R3: Mode 0 (2'b00) holds fmt_o at code_a_i.
- R4: Mode 1 (2'b01) toggles at the end of each interval. If fmt_o equals code_a_i it moves to code_b_i, otherwise it moves to code_a_i.
- R5: Mode 2 (2'b10) steps at the end of each interval. If fmt_o equals code_b_i it moves to code_a_i, otherwise it moves to fmt_o + 1 modulo 16.
- R6: Mode 3 (2'b11) holds fmt_o at code_b_i.
- R7: A change of mode_i, code_a_i or code_b_i, seen at a clock edge, sets fmt_o to the start code of the new mode on that edge and restarts the interval. The next timed step then comes PERIOD_CYC cycles later.
- R8: new_src_o is high for exactly the cycle after an edge where fmt_o took a different value, and low in every other cycle. This excludes the load after reset.
- R9: The interval length PERIOD_CYC equals CLK_HZ × INTERVAL_S clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Switching pattern select |
| code_a_i | input | 4 | First format code |
| code_b_i | input | 4 | Second format code |
| fmt_o | output | 4 | Format select sent to the pattern generator |
| new_src_o | output | 1 | One-cycle pulse when fmt_o changes |

## Verification
The bench covers these corner cases:
- A code change that leaves fmt_o where it was. A design that pulses on every input change would emit a new-source pulse here with no change of source.
- A step sequence where A is greater than B. This forces the wrap from 15 to 0. Without modulo-16 stepping the design would stall or take the wrong path.
- A change in the middle of an interval. This exposes a timer that is not restarted, because the next step would arrive early.
- A toggle with A equal to B. This must stay silent.
- A reset asserted in the middle of a run while mode 3 is selected. This checks that the start code comes from B, and that the post-reset load raises no pulse.

// File: rtl/fsw_pkg.sv
package fsw_pkg;
  typedef enum logic [1:0] {
    MODE_HOLD_A = 2'd0,
    MODE_TOGGLE = 2'd1,
    MODE_STEP   = 2'd2,
    MODE_HOLD_B = 2'd3
  } fsw_mode_e;
endpackage

// File: rtl/fsw_cfg_track.sv
module fsw_cfg_track #(
  parameter int unsigned CODE_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        mode_i,
  input  logic [CODE_W-1:0] code_a_i,
  input  logic [CODE_W-1:0] code_b_i,
  output logic [1:0]        mode_q_o,
  output logic [CODE_W-1:0] code_a_q_o,
  output logic [CODE_W-1:0] code_b_q_o,
  output logic              init_o,
  output logic              chg_o
);
  localparam int unsigned CFG_W = 2 + 2 * CODE_W;

  logic [CFG_W-1:0] cfg_d, cfg_q;
  logic             init_q;

  assign cfg_d = {mode_i, code_a_i, code_b_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q  <= '0;
      init_q <= 1'b1;
    end else begin
      cfg_q  <= cfg_d;
      init_q <= 1'b0;
    end
  end

  assign init_o     = init_q;
  assign chg_o      = !init_q && (cfg_d != cfg_q);
  assign mode_q_o   = cfg_q[CFG_W-1 -: 2];
  assign code_a_q_o = cfg_q[2*CODE_W-1 -: CODE_W];
  assign code_b_q_o = cfg_q[CODE_W-1:0];
endmodule

// File: rtl/fsw_period_timer.sv
module fsw_period_timer #(
  parameter int unsigned PERIOD_CYC = 300_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  output logic tick_o
);
  localparam int unsigned CNT_W = (PERIOD_CYC > 1) ? $clog2(PERIOD_CYC) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD_CYC - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             at_end;

  assign at_end = (cnt_q == LAST);
  assign tick_o = at_end && !restart_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (restart_i || at_end) cnt_q <= '0;
    else                          cnt_q <= cnt_q + 1'b1;
  end

  // R7: a restart always brings the count back to zero
  assert_restart_clears_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> cnt_q == '0);
  // R9: the count never leaves the interval
  assert_cnt_in_range_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
endmodule

// File: rtl/fsw_fmt_step.sv
module fsw_fmt_step
  import fsw_pkg::*;
#(
  parameter int unsigned CODE_W = 4
) (
  input  logic [1:0]        mode_i,
  input  logic [CODE_W-1:0] code_a_i,
  input  logic [CODE_W-1:0] code_b_i,
  input  logic [CODE_W-1:0] cur_i,
  output logic [CODE_W-1:0] start_o,
  output logic [CODE_W-1:0] next_o
);
  fsw_mode_e mode;
  assign mode = fsw_mode_e'(mode_i);

  always_comb begin
    start_o = (mode == MODE_HOLD_B) ? code_b_i : code_a_i;
    unique case (mode)
      MODE_HOLD_A: next_o = code_a_i;
      MODE_TOGGLE: next_o = (cur_i == code_a_i) ? code_b_i : code_a_i;
      MODE_STEP:   next_o = (cur_i == code_b_i) ? code_a_i : cur_i + 1'b1;
      MODE_HOLD_B: next_o = code_b_i;
      default:     next_o = code_a_i;
    endcase
  end
endmodule

// File: rtl/fsw_out_stage.sv
module fsw_out_stage #(
  parameter int unsigned CODE_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              init_i,
  input  logic              chg_i,
  input  logic              tick_i,
  input  logic [CODE_W-1:0] start_i,
  input  logic [CODE_W-1:0] next_i,
  output logic [CODE_W-1:0] fmt_o,
  output logic              pulse_o
);
  logic [CODE_W-1:0] fmt_q;
  logic              pulse_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fmt_q   <= '0;
      pulse_q <= 1'b0;
    end else if (init_i) begin
      fmt_q   <= start_i;
      pulse_q <= 1'b0;
    end else if (chg_i) begin
      fmt_q   <= start_i;
      pulse_q <= (start_i != fmt_q);
    end else if (tick_i) begin
      fmt_q   <= next_i;
      pulse_q <= (next_i != fmt_q);
    end else begin
      pulse_q <= 1'b0;
    end
  end

  assign fmt_o   = fmt_q;
  assign pulse_o = pulse_q;

  // R8: a pulse always marks a new value
  assert_pulse_means_change_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |-> fmt_o != $past(fmt_o));
  // R8: every new value outside the reset load is announced
  assert_change_means_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fmt_o != $past(fmt_o)) && !$past(init_i) |-> pulse_o);
  // R2: the post-reset load is silent
  assert_init_silent_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_i |=> !pulse_o);
endmodule

// File: rtl/fsw_sequencer.sv
module fsw_sequencer
  import fsw_pkg::*;
#(
  parameter int unsigned CLK_HZ     = 100_000_000,
  parameter int unsigned INTERVAL_S = 3,
  parameter int unsigned CODE_W     = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        mode_i,
  input  logic [CODE_W-1:0] code_a_i,
  input  logic [CODE_W-1:0] code_b_i,
  output logic [CODE_W-1:0] fmt_o,
  output logic              new_src_o
);
  localparam int unsigned PERIOD_CYC = CLK_HZ * INTERVAL_S;

  logic [1:0]        mode_q;
  logic [CODE_W-1:0] code_a_q, code_b_q;
  logic              init, chg, tick;
  logic [CODE_W-1:0] start_code, next_code;

  fsw_cfg_track #(.CODE_W(CODE_W)) u_cfg (
    .clk_i, .rst_ni, .mode_i, .code_a_i, .code_b_i,
    .mode_q_o(mode_q), .code_a_q_o(code_a_q), .code_b_q_o(code_b_q),
    .init_o(init), .chg_o(chg)
  );

  fsw_period_timer #(.PERIOD_CYC(PERIOD_CYC)) u_timer (
    .clk_i, .rst_ni, .restart_i(init | chg), .tick_o(tick)
  );

  fsw_fmt_step #(.CODE_W(CODE_W)) u_step (
    .mode_i, .code_a_i, .code_b_i, .cur_i(fmt_o),
    .start_o(start_code), .next_o(next_code)
  );

  fsw_out_stage #(.CODE_W(CODE_W)) u_out (
    .clk_i, .rst_ni, .init_i(init), .chg_i(chg), .tick_i(tick),
    .start_i(start_code), .next_i(next_code),
    .fmt_o, .pulse_o(new_src_o)
  );

  // R3: hold-A mode shows the registered A code
  assert_hold_a_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !init && (mode_q == MODE_HOLD_A) |-> fmt_o == code_a_q);
  // R6: hold-B mode shows the registered B code
  assert_hold_b_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !init && (mode_q == MODE_HOLD_B) |-> fmt_o == code_b_q);
  // R4: toggle mode only ever shows A or B
  assert_toggle_set_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !init && (mode_q == MODE_TOGGLE) |-> (fmt_o == code_a_q) || (fmt_o == code_b_q));
endmodule

// File: tb/tb_fsw_sequencer.sv
module tb_fsw_sequencer;
  localparam int unsigned CLK_HZ = 10;
  localparam int unsigned INT_S  = 1;
  localparam int PER = CLK_HZ * INT_S;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode = 2'd0;
  logic [3:0] ca = 4'd0, cb = 4'd0;
  logic [3:0] fmt;
  logic       nsrc;

  fsw_sequencer #(.CLK_HZ(CLK_HZ), .INTERVAL_S(INT_S), .CODE_W(4)) dut (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .code_a_i(ca), .code_b_i(cb),
    .fmt_o(fmt), .new_src_o(nsrc)
  );

  always #5 clk = ~clk;

  int n_cmp = 0, n_bad = 0, cycles = 0;
  string tag = "R1";

  // behavioural reference
  int m_fmt = 0, m_pulse = 0, m_cnt = 0, m_init = 1;
  int m_mode = 0, m_a = 0, m_b = 0;

  function automatic int start_of(int md, int a, int b);
    return (md == 3) ? b : a;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_fmt = 0; m_pulse = 0; m_cnt = 0; m_init = 1;
      m_mode = 0; m_a = 0; m_b = 0;
    end else begin
      int nv;
      if (m_init == 1) begin
        m_fmt = start_of(mode, ca, cb); m_pulse = 0; m_cnt = 0; m_init = 0;
      end else if (mode != m_mode || ca != m_a || cb != m_b) begin
        nv = start_of(mode, ca, cb);
        m_pulse = (nv != m_fmt); m_fmt = nv; m_cnt = 0;
      end else if (m_cnt == PER - 1) begin
        case (mode)
          0: nv = ca;
          1: nv = (m_fmt == ca) ? cb : ca;
          2: nv = (m_fmt == cb) ? ca : (m_fmt + 1) % 16;
          default: nv = cb;
        endcase
        m_pulse = (nv != m_fmt); m_fmt = nv; m_cnt = 0;
      end else begin
        m_pulse = 0; m_cnt = m_cnt + 1;
      end
      m_mode = mode; m_a = ca; m_b = cb;
    end
  end

  always @(negedge clk) begin
    cycles++;
    n_cmp++;
    if (fmt !== 4'(m_fmt) || nsrc !== 1'(m_pulse)) begin
      n_bad++;
      $display("FAIL %s t=%0t: fmt=%0d new_src=%0b expected fmt=%0d new_src=%0d",
               tag, $time, fmt, nsrc, m_fmt, m_pulse);
    end
    if (cycles > 100000) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic wait_cyc(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic set_in(int md, int a, int b);
    mode = 2'(md); ca = 4'(a); cb = 4'(b);
  endtask

  initial begin
    int first_p, second_p;
    // R1: held in reset
    set_in(0, 3, 6);
    wait_cyc(3);
    // R2: release, expect A loaded silently
    tag = "R2";
    @(negedge clk); #2 rst_n = 1'b1;
    wait_cyc(3);
    tag = "R3";
    wait_cyc(3 * PER);
    // R3: A change under hold-A
    set_in(0, 9, 6);
    wait_cyc(2 * PER);
    // R4: toggle, entry leaves fmt at A (no pulse)
    tag = "R4";
    set_in(1, 9, 11);
    wait_cyc(4 * PER);
    // R9: measure spacing of pulses in toggle mode
    tag = "R9";
    first_p = -1; second_p = -1;
    for (int i = 0; i < 3 * PER && second_p < 0; i++) begin
      @(negedge clk);
      if (nsrc) begin
        if (first_p < 0) first_p = i; else second_p = i;
      end
    end
    n_cmp++;
    if (second_p - first_p != PER) begin
      n_bad++;
      $display("FAIL R9: pulse spacing=%0d expected %0d", second_p - first_p, PER);
    end
    // R4: toggle with A == B stays silent
    tag = "R4";
    set_in(1, 7, 7);
    wait_cyc(3 * PER);
    // R5: step with wrap through 15
    tag = "R5";
    set_in(2, 13, 2);
    wait_cyc(8 * PER);
    set_in(2, 4, 8);
    wait_cyc(6 * PER);
    set_in(2, 5, 5);
    wait_cyc(2 * PER);
    // R6: hold-B
    tag = "R6";
    set_in(3, 1, 12);
    wait_cyc(3 * PER);
    // R7: mid-interval change restarts the timer
    tag = "R7";
    set_in(1, 2, 4);
    wait_cyc(PER + 4);
    set_in(1, 2, 6);
    wait_cyc(PER - 1);
    n_cmp++;
    if (fmt !== 4'd2 || nsrc !== 1'b0) begin
      n_bad++;
      $display("FAIL R7: fmt=%0d new_src=%0b expected fmt=2 new_src=0 before restarted interval ends",
               fmt, nsrc);
    end
    wait_cyc(2 * PER);
    // R8: change that keeps fmt gives no pulse
    tag = "R8";
    set_in(3, 0, 5);
    wait_cyc(3);
    set_in(3, 9, 5);
    wait_cyc(3);
    set_in(1, 5, 5);
    wait_cyc(PER + 2);
    // R2: reset mid-run in hold-B mode, start code from B
    tag = "R1";
    set_in(3, 1, 14);
    wait_cyc(2);
    #2 rst_n = 1'b0;
    wait_cyc(3);
    tag = "R2";
    #2 rst_n = 1'b1;
    wait_cyc(2 * PER);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule